// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Front End

This block is the bus-facing side of a 128K x 8 serial memory that answers as a slave on a two-wire I2C bus. It samples SCL and SDA with the system clock through a short synchroniser, finds start and stop conditions, and decodes the first byte after each start as a control byte. That byte carries a fixed device-type code, one block-select bit, two chip-select bits and a direction bit. The block answers only when the chip-select bits match two strap inputs and a third enable strap is high. SDA is driven only by pulling it low through an output enable, so the pad can be open-drain.

After a write-direction control byte, the block gathers a 17-bit word address and then passes each data byte, with its address, to a separate write-cycle unit over a valid/ready pair. Reads fetch bytes from a synchronous RAM port and shift them out MSB first. One address pointer serves random, current-address and sequential reads. It advances inside the 64K-byte half chosen by the block-select bit. While the write-cycle unit reports busy, no control byte is acknowledged, so a host can poll for the end of a write cycle.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A falling SDA edge while SCL is high starts control-byte reception. A rising SDA edge while SCL is high returns the block to idle with SDA released.
- R2: The control byte arrives MSB first. Bits 7:4 must be 1010, bit 2 must equal `chip_sel1_i` and bit 1 must equal `chip_sel0_i` for an acknowledge. On a mismatch SDA stays released for that byte and for every later byte until the next start.
- R3: While `chip_en_i` is low the block never drives SDA, whatever the bus traffic.
- R4: While `wcyc_busy_i` is high at the end of a control byte, that byte is not acknowledged.
- R5: Control bit 3 becomes address bit 16. After a write control byte (bit 0 = 0), a high address byte (bits 15:8) and then a low byte (bits 7:0) are each acknowledged. Each following data byte is acknowledged and presented on `wr_addr_o`/`wr_data_o` with its address.
- R6: `wr_valid_o` stays high, with address and data unchanged, until `wr_ready_i` is seen. Every accepted byte moves the pointer on by one, so consecutive bytes go to consecutive addresses.
- R7: After a read control byte (bit 0 = 1), the byte at the pointer is driven MSB first. A 0 bit is driven by asserting `sda_oe_o` during SCL low. SDA is released for the master's acknowledge bit.
- R8: When the master acknowledges a read byte, the next byte comes from the next address. Bits 15:0 wrap from FFFFh to 0000h, and bit 16 never changes from an increment.
- R9: When the master does not acknowledge a read byte, SDA stays released until the next start or stop.
- R10: A read control byte sent without a preceding address uses the pointer left by the last access (last address plus one). Bit 16 is taken from that control byte's bit 3.
- R11: A repeated start in the middle of a byte abandons that byte and restarts control-byte reception. The address pointer keeps its value.
- R12: An acknowledge asserts `sda_oe_o` from the SCL falling edge after the eighth bit until the next SCL falling edge. It is never raised while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High pulls SDA low |
| chip_sel0_i | input | 1 | Strap compared with control bit 1 |
| chip_sel1_i | input | 1 | Strap compared with control bit 2 |
| chip_en_i | input | 1 | Strap; low silences the block |
| wcyc_busy_i | input | 1 | Write-cycle unit is programming |
| wr_valid_o | output | 1 | Write byte offered |
| wr_ready_i | input | 1 | Write-cycle unit accepts the byte |
| wr_addr_o | output | 17 | Address of the offered byte |
| wr_data_o | output | 8 | Offered byte |
| rd_en_o | output | 1 | Read strobe to the RAM port |
| rd_addr_o | output | 17 | Read address |
| rd_data_i | input | 8 | RAM data, valid the cycle after `rd_en_o` |

## Verification
The assertions assume that each SCL low or high phase lasts longer than the synchroniser delay plus the three-cycle read prefetch. Without that, the acknowledge window and the first data bit could not be placed inside SCL low. They also assume that SDA changes only while SCL is low, except at starts and stops. The bench master holds every bus phase for eight system clocks and changes SDA only in low phases, except where it means to signal a start or stop. It models the wired-AND line from its own pull-down and `sda_oe_o`.

// File: rtl/eei_pkg.sv
package eei_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 17;
    localparam int HALF_W = ADDR_W - 1;
    localparam int CNT_W  = 4;
    localparam logic [3:0] DEV_TYPE = 4'b1010;

    typedef enum logic [3:0] {
        ST_IDLE, ST_CTRL, ST_ACK_C, ST_AHI, ST_ACK_H, ST_ALO, ST_ACK_L,
        ST_WDATA, ST_ACK_W, ST_RDATA, ST_RACK, ST_IGNORE
    } ctl_state_e;

    typedef struct packed {
        ctl_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [BYTE_W-1:0]  rx;
        logic [BYTE_W-1:0]  tx;
        logic               oe;
        logic               rw;
        logic               mack;
        logic               fetch;
        logic               pend;
        logic               wv;
        logic [BYTE_W-1:0]  wd;
        logic [ADDR_W-1:0]  wa;
    } ctl_regs_t;
endpackage

// File: rtl/eei_line_sync.sv
module eei_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_ff_d, scl_ff_q, sda_ff_d, sda_ff_q;
    logic scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            assign scl_ff_d[g] = scl_i;
            assign sda_ff_d[g] = sda_i;
        end else begin : g_next
            assign scl_ff_d[g] = scl_ff_q[g-1];
            assign sda_ff_d[g] = sda_ff_q[g-1];
        end
    end

    always_comb begin
        scl_prev_d = scl_ff_q[STAGES-1];
        sda_prev_d = sda_ff_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff_q   <= '1;
            sda_ff_q   <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_ff_q   <= scl_ff_d;
            sda_ff_q   <= sda_ff_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o      = scl_ff_q[STAGES-1];
    assign sda_o      = sda_ff_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/eei_addr_ptr.sv
module eei_addr_ptr
    import eei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_blk_i,
    input  logic              blk_i,
    input  logic              set_hi_i,
    input  logic              set_lo_i,
    input  logic [BYTE_W-1:0] byte_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] ptr_o
);
    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (set_blk_i) ptr_d[ADDR_W-1] = blk_i;
        if (set_hi_i)  ptr_d[HALF_W-1:BYTE_W] = byte_i;
        if (set_lo_i)  ptr_d[BYTE_W-1:0] = byte_i;
        if (inc_i)     ptr_d[HALF_W-1:0] = ptr_q[HALF_W-1:0] + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;

    AST_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !set_blk_i) |=> (ptr_q[ADDR_W-1] == $past(ptr_q[ADDR_W-1]))); // R8
    AST_LOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !set_lo_i && !set_hi_i && (&ptr_q[HALF_W-1:0])) |=> (ptr_q[HALF_W-1:0] == '0)); // R8
endmodule

// File: rtl/eei_ctrl.sv
module eei_ctrl
    import eei_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s_i,
    input  logic              sda_s_i,
    input  logic              scl_rise_i,
    input  logic              scl_fall_i,
    input  logic              start_i,
    input  logic              stop_i,
    input  logic              sel0_i,
    input  logic              sel1_i,
    input  logic              en_i,
    input  logic              busy_i,
    input  logic              wr_ready_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic              sda_oe_o,
    output logic              set_blk_o,
    output logic              blk_o,
    output logic              set_hi_o,
    output logic              set_lo_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              inc_o,
    output logic              rd_en_o,
    output logic              wr_valid_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W);

    ctl_regs_t r_q, r_d;
    logic      byte_done, ctrl_match;

    assign byte_done  = scl_fall_i && (r_q.cnt == LAST_BIT);
    assign ctrl_match = (r_q.rx[7:4] == DEV_TYPE) && (r_q.rx[2] == sel1_i) &&
                        (r_q.rx[1] == sel0_i) && !busy_i;

    always_comb begin
        r_d       = r_q;
        set_blk_o = 1'b0;
        set_hi_o  = 1'b0;
        set_lo_o  = 1'b0;
        inc_o     = 1'b0;
        blk_o     = r_q.rx[3];
        byte_o    = r_q.rx;

        r_d.fetch = 1'b0;
        r_d.pend  = r_q.fetch;
        if (r_q.pend) r_d.tx = rd_data_i;
        if (r_q.wv && wr_ready_i) begin
            r_d.wv = 1'b0;
            inc_o  = 1'b1;
        end

        if (!en_i) begin
            r_d.st  = ST_IDLE;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else if (stop_i) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_i) begin
            r_d.st  = ST_CTRL;
            r_d.oe  = 1'b0;
            r_d.cnt = '0;
        end else begin
            unique case (r_q.st)
                ST_IDLE, ST_IGNORE: ;
                ST_CTRL, ST_AHI, ST_ALO, ST_WDATA: begin
                    if (scl_rise_i) begin
                        r_d.rx  = {r_q.rx[BYTE_W-2:0], sda_s_i};
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (byte_done) begin
                        r_d.cnt = '0;
                        r_d.oe  = 1'b1;
                        case (r_q.st)
                            ST_CTRL: begin
                                if (ctrl_match) begin
                                    set_blk_o = 1'b1;
                                    r_d.rw    = r_q.rx[0];
                                    r_d.fetch = r_q.rx[0];
                                    r_d.st    = ST_ACK_C;
                                end else begin
                                    r_d.oe = 1'b0;
                                    r_d.st = ST_IGNORE;
                                end
                            end
                            ST_AHI: begin
                                set_hi_o = 1'b1;
                                r_d.st   = ST_ACK_H;
                            end
                            ST_ALO: begin
                                set_lo_o = 1'b1;
                                r_d.st   = ST_ACK_L;
                            end
                            default: begin
                                r_d.wv = 1'b1;
                                r_d.wd = r_q.rx;
                                r_d.wa = ptr_i;
                                r_d.st = ST_ACK_W;
                            end
                        endcase
                    end
                end
                ST_ACK_C: begin
                    if (scl_fall_i) begin
                        r_d.cnt = '0;
                        if (r_q.rw) begin
                            r_d.st = ST_RDATA;
                            r_d.oe = ~r_q.tx[BYTE_W-1];
                        end else begin
                            r_d.st = ST_AHI;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                ST_ACK_H: if (scl_fall_i) begin r_d.st = ST_ALO;   r_d.oe = 1'b0; end
                ST_ACK_L: if (scl_fall_i) begin r_d.st = ST_WDATA; r_d.oe = 1'b0; end
                ST_ACK_W: if (scl_fall_i) begin r_d.st = ST_WDATA; r_d.oe = 1'b0; end
                ST_RDATA: begin
                    if (scl_rise_i) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else if (byte_done) begin
                        r_d.cnt   = '0;
                        r_d.oe    = 1'b0;
                        r_d.st    = ST_RACK;
                        inc_o     = 1'b1;
                        r_d.fetch = 1'b1;
                    end else if (scl_fall_i) begin
                        r_d.tx = {r_q.tx[BYTE_W-2:0], 1'b0};
                        r_d.oe = ~r_q.tx[BYTE_W-2];
                    end
                end
                ST_RACK: begin
                    if (scl_rise_i) begin
                        r_d.mack = ~sda_s_i;
                    end else if (scl_fall_i) begin
                        r_d.cnt = '0;
                        if (r_q.mack) begin
                            r_d.st = ST_RDATA;
                            r_d.oe = ~r_q.tx[BYTE_W-1];
                        end else begin
                            r_d.st = ST_IGNORE;
                            r_d.oe = 1'b0;
                        end
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o   = r_q.oe;
    assign rd_en_o    = r_q.fetch;
    assign wr_valid_o = r_q.wv;
    assign wr_addr_o  = r_q.wa;
    assign wr_data_o  = r_q.wd;

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> !sda_oe_o); // R1
    AST_SILENT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !sda_oe_o); // R3
    AST_BUSY_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !start_i && !stop_i && busy_i && r_q.st == ST_CTRL && byte_done) |=> !sda_oe_o); // R4
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o))); // R6
    AST_OE_RISE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_s_i); // R12
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
    import eei_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              chip_sel0_i,
    input  logic              chip_sel1_i,
    input  logic              chip_en_i,
    input  logic              wcyc_busy_i,
    output logic              wr_valid_o,
    input  logic              wr_ready_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [BYTE_W-1:0] rd_data_i
);
    logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
    logic set_blk, blk, set_hi, set_lo, inc;
    logic [BYTE_W-1:0] ld_byte;
    logic [ADDR_W-1:0] ptr;

    eei_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall), .start_o(start), .stop_o(stop)
    );

    eei_addr_ptr u_ptr (
        .clk(clk), .rst_n(rst_n), .set_blk_i(set_blk), .blk_i(blk),
        .set_hi_i(set_hi), .set_lo_i(set_lo), .byte_i(ld_byte),
        .inc_i(inc), .ptr_o(ptr)
    );

    eei_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
        .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .start_i(start),
        .stop_i(stop), .sel0_i(chip_sel0_i), .sel1_i(chip_sel1_i),
        .en_i(chip_en_i), .busy_i(wcyc_busy_i), .wr_ready_i(wr_ready_i),
        .rd_data_i(rd_data_i), .ptr_i(ptr), .sda_oe_o(sda_oe_o),
        .set_blk_o(set_blk), .blk_o(blk), .set_hi_o(set_hi),
        .set_lo_o(set_lo), .byte_o(ld_byte), .inc_o(inc),
        .rd_en_o(rd_en_o), .wr_valid_o(wr_valid_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o)
    );

    assign rd_addr_o = ptr;
endmodule

// File: tb/sim_eeprom_i2c_slave.sv
module sim_eeprom_i2c_slave;
    localparam int CLK_PERIOD = 10;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sel0 = 1'b0, sel1 = 1'b1, en = 1'b1, busy = 1'b0, wready = 1'b1;
    logic sda_oe, wvalid, rd_en;
    logic [16:0] waddr, rd_addr;
    logic [7:0] wdata, rd_data;
    logic sda_line;
    int nchk = 0, nfail = 0, log_n = 0;
    logic [16:0] log_a;
    logic [7:0] log_d;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = !(m_low || sda_oe);

    eeprom_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .chip_sel0_i(sel0), .chip_sel1_i(sel1),
        .chip_en_i(en), .wcyc_busy_i(busy), .wr_valid_o(wvalid),
        .wr_ready_i(wready), .wr_addr_o(waddr), .wr_data_o(wdata),
        .rd_en_o(rd_en), .rd_addr_o(rd_addr), .rd_data_i(rd_data)
    );

    function automatic logic [7:0] memf(input logic [16:0] a);
        return a[7:0] ^ a[15:8] ^ (a[16] ? 8'hA5 : 8'h3C);
    endfunction

    always @(posedge clk) begin
        if (rd_en) rd_data <= memf(rd_addr);
        if (wvalid && wready) begin
            log_n <= log_n + 1;
            log_a <= waddr;
            log_d <= wdata;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; wait_clk(H);
        m_low = 1'b1; wait_clk(H);
        scl = 1'b0;   wait_clk(H);
    endtask

    task automatic bus_rstart();
        m_low = 1'b0; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        m_low = 1'b1; wait_clk(H);
        scl = 1'b0;   wait_clk(H);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; wait_clk(H);
        scl = 1'b1;   wait_clk(H);
        m_low = 1'b0; wait_clk(H);
    endtask

    task automatic drv_bit(input logic b);
        m_low = !b; wait_clk(H);
        scl = 1'b1; wait_clk(H);
        scl = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack, input bit chk_rel);
        for (int i = 7; i >= 0; i--) drv_bit(b[i]);
        m_low = 1'b0; wait_clk(H);
        scl = 1'b1; wait_clk(H/2);
        ack = !sda_line;
        wait_clk(H/2);
        scl = 1'b0;
        if (chk_rel) begin
            wait_clk(H/2);
            chk(sda_oe == 1'b0, "R12 ack released after next fall", sda_oe, 0);
        end
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic give_ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            wait_clk(H);
            scl = 1'b1; wait_clk(H/2);
            d[i] = sda_line;
            wait_clk(H/2);
            scl = 1'b0;
        end
        m_low = give_ack; wait_clk(H);
        scl = 1'b1; wait_clk(H/2);
        chk(sda_oe == 1'b0, "R7 released for master ack", sda_oe, 0);
        wait_clk(H/2);
        scl = 1'b0;
        m_low = 1'b0;
    endtask

    task automatic t_reset();
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        chk(wvalid == 1'b0, "R6 reset valid", wvalid, 0);
        chk(rd_en == 1'b0, "R7 reset rd_en", rd_en, 0);
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'hAC, a, 0); chk(a, "R2 control ack", a, 1);
        send_byte(8'h12, a, 1); chk(a, "R5 addr hi ack", a, 1);
        send_byte(8'h34, a, 1); chk(a, "R5 addr lo ack", a, 1);
        send_byte(8'h5A, a, 1); chk(a, "R5 data ack", a, 1);
        wait_clk(2);
        chk(log_a == 17'h11234 && log_d == 8'h5A, "R5 write addr/data", {log_a, log_d}, {17'h11234, 8'h5A});
        send_byte(8'h6B, a, 1);
        wait_clk(2);
        chk(log_a == 17'h11235 && log_d == 8'h6B, "R6 next write addr", {log_a, log_d}, {17'h11235, 8'h6B});
        bus_stop();
        chk(sda_oe == 1'b0, "R1 stop releases", sda_oe, 0);
    endtask

    task automatic t_random_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA4, a, 0);
        send_byte(8'hFF, a, 0);
        send_byte(8'hFE, a, 0);
        bus_rstart();
        send_byte(8'hA5, a, 0); chk(a, "R11 read control after rstart", a, 1);
        recv_byte(d, 1); chk(d == memf(17'h0FFFE), "R7 random read", d, memf(17'h0FFFE));
        recv_byte(d, 1); chk(d == memf(17'h0FFFF), "R8 sequential next", d, memf(17'h0FFFF));
        recv_byte(d, 0); chk(d == memf(17'h00000), "R8 wrap low half", d, memf(17'h00000));
        wait_clk(H);
        chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
        bus_stop();
        bus_start();
        send_byte(8'hAC, a, 0);
        send_byte(8'hFF, a, 0);
        send_byte(8'hFF, a, 0);
        bus_rstart();
        send_byte(8'hAD, a, 0);
        recv_byte(d, 1); chk(d == memf(17'h1FFFF), "R7 upper half read", d, memf(17'h1FFFF));
        recv_byte(d, 0); chk(d == memf(17'h10000), "R8 wrap keeps bit16", d, memf(17'h10000));
        bus_stop();
    endtask

    task automatic t_current_read();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hAD, a, 0); chk(a, "R10 current read ack", a, 1);
        recv_byte(d, 0); chk(d == memf(17'h10001), "R10 last plus one", d, memf(17'h10001));
        bus_stop();
        bus_start();
        send_byte(8'hA5, a, 0);
        recv_byte(d, 0); chk(d == memf(17'h00002), "R10 bit16 from control", d, memf(17'h00002));
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte(8'hA8, a, 0); chk(!a, "R2 chip bit 2 mismatch", a, 0);
        send_byte(8'hA4, a, 0); chk(!a, "R2 silent until start", a, 0);
        bus_rstart();
        send_byte(8'hA6, a, 0); chk(!a, "R2 chip bit 1 mismatch", a, 0);
        bus_rstart();
        send_byte(8'hB4, a, 0); chk(!a, "R2 type code mismatch", a, 0);
        bus_stop();
    endtask

    task automatic t_busy();
        logic a;
        busy = 1'b1;
        bus_start();
        send_byte(8'hA4, a, 0); chk(!a, "R4 no ack while busy", a, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hA4, a, 0); chk(a, "R4 ack after busy", a, 1);
        bus_stop();
    endtask

    task automatic t_disabled();
        logic a;
        en = 1'b0;
        bus_start();
        send_byte(8'hA4, a, 0); chk(!a, "R3 strap low no ack", a, 0);
        chk(sda_oe == 1'b0, "R3 strap low oe", sda_oe, 0);
        bus_stop();
        en = 1'b1;
    endtask

    task automatic t_abort();
        logic a;
        logic [7:0] d;
        bus_start();
        send_byte(8'hA4, a, 0);
        drv_bit(1'b0); drv_bit(1'b1); drv_bit(1'b1); drv_bit(1'b1);
        bus_rstart();
        send_byte(8'hA5, a, 0); chk(a, "R11 control after abort", a, 1);
        recv_byte(d, 0); chk(d == memf(17'h00003), "R11 pointer kept", d, memf(17'h00003));
        bus_stop();
    endtask

    task automatic t_wready();
        logic a;
        int n0;
        wready = 1'b0;
        bus_start();
        send_byte(8'hA4, a, 0);
        send_byte(8'h00, a, 0);
        send_byte(8'h10, a, 0);
        n0 = log_n;
        send_byte(8'h99, a, 0); chk(a, "R5 data ack while not ready", a, 1);
        chk(wvalid && waddr == 17'h00010 && wdata == 8'h99, "R6 offer held", {wvalid, waddr, wdata}, {1'b1, 17'h00010, 8'h99});
        wait_clk(20);
        chk(wvalid == 1'b1, "R6 valid held", wvalid, 1);
        wready = 1'b1;
        wait_clk(2);
        chk(log_n == n0 + 1 && log_a == 17'h00010, "R6 accepted once", log_a, 17'h00010);
        send_byte(8'h9A, a, 0);
        wait_clk(2);
        chk(log_a == 17'h00011 && log_d == 8'h9A, "R6 next address", {log_a, log_d}, {17'h00011, 8'h9A});
        bus_stop();
    endtask

    initial begin
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
        t_reset();
        t_write();
        t_random_read();
        t_current_read();
        t_mismatch();
        t_busy();
        t_disabled();
        t_abort();
        t_wready();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule